// File: doc/BRIEF.md
# Commit-Stage Squash Controller

This block sits beside the reorder buffer at the retirement end of a multithreaded out-of-order core and decides, per hardware thread, when and where that thread's in-flight work must be thrown away. Three kinds of request can ask for a flush. A trap request is armed now and fires only after a programmable number of cycles. A thread-context request fires on the following cycle. A branch or replay squash from the execute stage is checked against the youngest instruction the thread has inserted so far.

For every accepted request the controller computes the squash boundary, which is the newest sequence number that survives. It drives the squash pulse, the boundary, a redirect PC and the branch outcome bits back to the front-end stages, and it holds a per-thread rob-squashing indication until the buffer reports that the flush is complete. A shared count of flushing threads is kept. When every thread is flushing, the block raises a hold that suppresses instruction insertion and commit. The reorder buffer itself is not part of the block. It appears only as per-thread done, empty and head-sequence inputs.

Top module: `commit_squash_ctrl`

## Requirements
- R1: After synchronous reset, every thread is idle with no pending trap or context request, no squash or rob-squashing output is high, the flushing-thread count is zero, the hold is low and the mispredict count reads zero.
- R2: A trap request that arrives while a thread is idle or running is sampled on edge k. It produces that thread's squash in the cycle after edge k+L, where L is the configured trap latency (0 behaves as 1). No squash appears before that.
- R3: If a thread has both a matured trap and a pending context request, the trap squash is issued, conflict_o is high for that cycle, and the context request stays pending and is issued in a later cycle. A context request is held back while the thread waits for its trap.
- R4: A trap or context squash flushes the whole thread. The boundary is the head sequence number minus one, or 0 when the buffer is empty. The redirect PC is the last committed PC of that thread. Mispredict and taken are low, and the thread's youngest sequence becomes 0.
- R5: An execute squash is accepted only if the thread is not waiting for a trap, no full-thread squash is issued for it that cycle, and its sequence number is less than or equal to the thread's youngest inserted sequence. A rejected squash has no effect. An insert that is not held sets the youngest sequence.
- R6: For an accepted execute squash, the boundary is the squash sequence minus one when the include flag is set, and the squash sequence otherwise. The youngest sequence becomes the boundary.
- R7: An accepted squash pulses squash_o for one cycle with the boundary on done_seq_o. Next PC, mispredict and taken are forwarded from the execute request. rob_squashing_o stays high from that cycle until the buffer reports done.
- R8: A flushing thread whose done input is high goes back to running in that cycle, and its rob_squashing_o drops in that same cycle. The flushing count falls by one, and the hold drops in that cycle if it was high.
- R9: hold_o is high in any cycle in which, after done threads are released and new squashes are counted, every thread is flushing. While hold_o is high, inserts and commits have no effect on the youngest sequence or the committed PC.
- R10: The mispredict count rises by the number of accepted execute squashes carrying the mispredict flag in each cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_trap_lat | input | LAT_W | Trap deferral in cycles |
| trap_req | input | NT | Trap request per thread |
| tc_req | input | NT | Thread-context squash request per thread |
| ex_squash | input | NT | Execute-stage squash request per thread |
| ex_seq | input | NT x SEQ_W | Sequence number of the execute squash |
| ex_incl | input | NT | Also squash the requesting instruction |
| ex_mispred | input | NT | Execute squash is a branch mispredict |
| ex_taken | input | NT | Branch outcome of the execute squash |
| ex_next_pc | input | NT x PC_W | Redirect target from execute |
| rob_done | input | NT | Buffer has finished flushing the thread |
| rob_empty | input | NT | Thread has no entries in the buffer |
| rob_head_seq | input | NT x SEQ_W | Sequence number at the thread's head |
| ins_valid | input | NT | Instruction inserted for the thread |
| ins_seq | input | NT x SEQ_W | Sequence number of the inserted instruction |
| com_valid | input | NT | Instruction committed for the thread |
| com_pc | input | NT x PC_W | PC of the committed instruction |
| squash_o | output | NT | Squash pulse per thread |
| rob_squashing_o | output | NT | Thread is flushing |
| done_seq_o | output | NT x SEQ_W | Squash boundary |
| redirect_pc_o | output | NT x PC_W | Fetch redirect PC |
| mispred_o | output | NT | Forwarded mispredict |
| taken_o | output | NT | Forwarded branch outcome |
| conflict_o | output | NT | Trap and context request met |
| hold_o | output | 1 | Suppress insertion and commit |
| mispred_cnt_o | output | MCNT_W | Accepted mispredict squashes |

## Verification
A corrupted youngest-sequence register shows up at the ports on the next execute squash. A request that should be rejected produces a squash pulse, or a valid one is dropped, and the scoreboard sees the mismatch within the same cycle. A wrong trap timer moves the squash pulse off its expected cycle by at least one cycle. A drifting flushing count shows up as a hold that comes too early or too late, visible in the first cycle in which the set of flushing threads changes. Wrong boundary or redirect arithmetic is caught at the squash pulse itself.

// File: rtl/csq_pkg.sv
package csq_pkg;

    typedef enum logic [1:0] {
        TH_IDLE     = 2'd0,
        TH_RUN      = 2'd1,
        TH_TRAPWAIT = 2'd2,
        TH_FLUSH    = 2'd3
    } th_state_e;

    function automatic logic th_can_arm(th_state_e s);
        return (s == TH_IDLE) || (s == TH_RUN);
    endfunction

endpackage

// File: rtl/csq_trap_timer.sv
module csq_trap_timer #(
    parameter int LAT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [LAT_W-1:0] lat,
    output logic             expire
);
    logic [LAT_W-1:0] cnt_q;
    logic [LAT_W-1:0] load_val;

    assign load_val = (lat == '0) ? LAT_W'(1) : lat;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (start) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - LAT_W'(1);
        end
    end

    assign expire = (cnt_q == LAT_W'(1)) && !start;
endmodule

// File: rtl/csq_thread.sv
module csq_thread
    import csq_pkg::*;
#(
    parameter int SEQ_W = 16,
    parameter int PC_W  = 32,
    parameter int LAT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LAT_W-1:0] trap_lat,
    input  logic             trap_req,
    input  logic             tc_req,
    input  logic             ex_sq,
    input  logic [SEQ_W-1:0] ex_seq,
    input  logic             ex_incl,
    input  logic             ex_mis,
    input  logic             ex_tkn,
    input  logic [PC_W-1:0]  ex_npc,
    input  logic             rob_done,
    input  logic             rob_empty,
    input  logic [SEQ_W-1:0] rob_head,
    input  logic             ins_v,
    input  logic [SEQ_W-1:0] ins_seq,
    input  logic             com_v,
    input  logic [PC_W-1:0]  com_pc,
    input  logic             hold,
    output logic             sq,
    output logic             rob_sq,
    output logic [SEQ_W-1:0] done_seq,
    output logic [PC_W-1:0]  redir,
    output logic             mis,
    output logic             tkn,
    output logic             conflict,
    output logic             enter,
    output logic             leave,
    output logic             flushing
);
    th_state_e        state_q, state_d;
    logic             trap_flag_q;
    logic             tc_flag_q;
    logic [SEQ_W-1:0] young_q;
    logic [PC_W-1:0]  pc_q;

    logic still_flush, trap_take, tc_take, full, ex_ok, trap_arm, expire;
    logic [SEQ_W-1:0] full_bound, ex_bound;

    assign leave       = (state_q == TH_FLUSH) && rob_done;
    assign still_flush = (state_q == TH_FLUSH) && !rob_done;

    // trap outranks context request; context waits while a trap is armed
    assign trap_take = trap_flag_q;
    assign tc_take   = tc_flag_q && !trap_flag_q && (state_q != TH_TRAPWAIT);
    assign full      = trap_take || tc_take;
    assign conflict  = trap_flag_q && tc_flag_q;

    assign ex_ok = ex_sq && !full && (state_q != TH_TRAPWAIT) && (ex_seq <= young_q);

    assign full_bound = rob_empty ? '0 : (rob_head - SEQ_W'(1));
    assign ex_bound   = ex_incl ? (ex_seq - SEQ_W'(1)) : ex_seq;

    assign sq       = full || ex_ok;
    assign enter    = sq && !still_flush;
    assign rob_sq   = sq || still_flush;
    assign done_seq = full ? full_bound : ex_bound;
    assign redir    = full ? pc_q : ex_npc;
    assign mis      = ex_ok && ex_mis;
    assign tkn      = ex_ok && ex_tkn;
    assign flushing = (state_q == TH_FLUSH);

    assign trap_arm = trap_req && !sq && th_can_arm(state_q);

    csq_trap_timer #(.LAT_W(LAT_W)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .start  (trap_arm),
        .lat    (trap_lat),
        .expire (expire)
    );

    always_comb begin
        state_d = state_q;
        if (sq) begin
            state_d = TH_FLUSH;
        end else if (trap_arm) begin
            state_d = TH_TRAPWAIT;
        end else if (leave) begin
            state_d = TH_RUN;
        end else if ((state_q == TH_IDLE) && ins_v && !hold) begin
            state_d = TH_RUN;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= TH_IDLE;
            trap_flag_q <= 1'b0;
            tc_flag_q   <= 1'b0;
            young_q     <= '0;
            pc_q        <= '0;
        end else begin
            state_q <= state_d;

            if (trap_take) begin
                trap_flag_q <= 1'b0;
            end else if (expire) begin
                trap_flag_q <= 1'b1;
            end

            if (tc_req) begin
                tc_flag_q <= 1'b1;
            end else if (tc_take) begin
                tc_flag_q <= 1'b0;
            end

            if (full) begin
                young_q <= '0;
            end else if (ex_ok) begin
                young_q <= ex_bound;
            end else if (ins_v && !hold) begin
                young_q <= ins_seq;
            end

            if (com_v && !hold) begin
                pc_q <= com_pc;
            end
        end
    end
endmodule

// File: rtl/csq_sq_count.sv
module csq_sq_count #(
    parameter int NT     = 4,
    parameter int MCNT_W = 16,
    parameter int CW     = $clog2(NT + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NT-1:0]     enter,
    input  logic [NT-1:0]     leave,
    input  logic [NT-1:0]     mis,
    output logic              hold,
    output logic [CW-1:0]     cnt,
    output logic [MCNT_W-1:0] mis_cnt
);
    logic [CW-1:0] cnt_q, cnt_d, n_enter, n_leave, n_mis;
    logic [MCNT_W-1:0] mis_q;

    always_comb begin
        n_enter = '0;
        n_leave = '0;
        n_mis   = '0;
        for (int i = 0; i < NT; i++) begin
            n_enter = n_enter + CW'(enter[i]);
            n_leave = n_leave + CW'(leave[i]);
            n_mis   = n_mis + CW'(mis[i]);
        end
        cnt_d = cnt_q - n_leave + n_enter;
    end

    assign hold    = (cnt_d == CW'(NT));
    assign cnt     = cnt_q;
    assign mis_cnt = mis_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            mis_q <= '0;
        end else begin
            cnt_q <= cnt_d;
            mis_q <= mis_q + MCNT_W'(n_mis);
        end
    end
endmodule

// File: rtl/commit_squash_ctrl.sv
module commit_squash_ctrl
    import csq_pkg::*;
#(
    parameter int NT     = 4,
    parameter int SEQ_W  = 16,
    parameter int PC_W   = 32,
    parameter int LAT_W  = 4,
    parameter int MCNT_W = 16
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [LAT_W-1:0]           cfg_trap_lat,
    input  logic [NT-1:0]              trap_req,
    input  logic [NT-1:0]              tc_req,
    input  logic [NT-1:0]              ex_squash,
    input  logic [NT-1:0][SEQ_W-1:0]   ex_seq,
    input  logic [NT-1:0]              ex_incl,
    input  logic [NT-1:0]              ex_mispred,
    input  logic [NT-1:0]              ex_taken,
    input  logic [NT-1:0][PC_W-1:0]    ex_next_pc,
    input  logic [NT-1:0]              rob_done,
    input  logic [NT-1:0]              rob_empty,
    input  logic [NT-1:0][SEQ_W-1:0]   rob_head_seq,
    input  logic [NT-1:0]              ins_valid,
    input  logic [NT-1:0][SEQ_W-1:0]   ins_seq,
    input  logic [NT-1:0]              com_valid,
    input  logic [NT-1:0][PC_W-1:0]    com_pc,
    output logic [NT-1:0]              squash_o,
    output logic [NT-1:0]              rob_squashing_o,
    output logic [NT-1:0][SEQ_W-1:0]   done_seq_o,
    output logic [NT-1:0][PC_W-1:0]    redirect_pc_o,
    output logic [NT-1:0]              mispred_o,
    output logic [NT-1:0]              taken_o,
    output logic [NT-1:0]              conflict_o,
    output logic                       hold_o,
    output logic [MCNT_W-1:0]          mispred_cnt_o
);
    localparam int CW = $clog2(NT + 1);

    logic [NT-1:0] enter_v, leave_v, flush_v;
    logic [CW-1:0] sq_cnt;
    logic          hold;

    for (genvar t = 0; t < NT; t++) begin : g_th
        csq_thread #(
            .SEQ_W (SEQ_W),
            .PC_W  (PC_W),
            .LAT_W (LAT_W)
        ) u_th (
            .clk      (clk),
            .rst      (rst),
            .trap_lat (cfg_trap_lat),
            .trap_req (trap_req[t]),
            .tc_req   (tc_req[t]),
            .ex_sq    (ex_squash[t]),
            .ex_seq   (ex_seq[t]),
            .ex_incl  (ex_incl[t]),
            .ex_mis   (ex_mispred[t]),
            .ex_tkn   (ex_taken[t]),
            .ex_npc   (ex_next_pc[t]),
            .rob_done (rob_done[t]),
            .rob_empty(rob_empty[t]),
            .rob_head (rob_head_seq[t]),
            .ins_v    (ins_valid[t]),
            .ins_seq  (ins_seq[t]),
            .com_v    (com_valid[t]),
            .com_pc   (com_pc[t]),
            .hold     (hold),
            .sq       (squash_o[t]),
            .rob_sq   (rob_squashing_o[t]),
            .done_seq (done_seq_o[t]),
            .redir    (redirect_pc_o[t]),
            .mis      (mispred_o[t]),
            .tkn      (taken_o[t]),
            .conflict (conflict_o[t]),
            .enter    (enter_v[t]),
            .leave    (leave_v[t]),
            .flushing (flush_v[t])
        );
    end

    csq_sq_count #(
        .NT     (NT),
        .MCNT_W (MCNT_W),
        .CW     (CW)
    ) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .enter   (enter_v),
        .leave   (leave_v),
        .mis     (mispred_o),
        .hold    (hold),
        .cnt     (sq_cnt),
        .mis_cnt (mispred_cnt_o)
    );

    assign hold_o = hold;
endmodule

// File: rtl/csq_checker.sv
module csq_checker #(
    parameter int NT     = 4,
    parameter int MCNT_W = 16,
    parameter int CW     = 3
) (
    input logic              clk,
    input logic              rst,
    input logic [NT-1:0]     squash_o,
    input logic [NT-1:0]     rob_squashing_o,
    input logic [NT-1:0]     mispred_o,
    input logic [NT-1:0]     conflict_o,
    input logic              hold_o,
    input logic [MCNT_W-1:0] mispred_cnt_o,
    input logic [CW-1:0]     sq_cnt,
    input logic [NT-1:0]     flush_v
);
    a_r1_reset_clear: assert property (@(posedge clk)
        $past(rst) |-> (mispred_cnt_o == '0) && (sq_cnt == '0));

    a_r8_count_tracks_flush: assert property (@(posedge clk) disable iff (rst)
        int'(sq_cnt) == $countones(flush_v));

    a_r9_hold_all_flushing: assert property (@(posedge clk) disable iff (rst)
        hold_o |-> (&rob_squashing_o));

    a_r10_mis_count: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> int'(mispred_cnt_o) ==
            ((int'($past(mispred_cnt_o)) + $countones($past(mispred_o))) % (2 ** MCNT_W)));

    for (genvar t = 0; t < NT; t++) begin : g_a
        a_r3_trap_wins: assert property (@(posedge clk) disable iff (rst)
            conflict_o[t] |-> squash_o[t] && !mispred_o[t]);

        a_r7_squash_to_flush: assert property (@(posedge clk) disable iff (rst)
            squash_o[t] |=> flush_v[t]);

        a_r7_flag_covers_pulse: assert property (@(posedge clk) disable iff (rst)
            squash_o[t] |-> rob_squashing_o[t]);
    end
endmodule

bind commit_squash_ctrl csq_checker #(
    .NT     (NT),
    .MCNT_W (MCNT_W),
    .CW     (CW)
) u_chk (
    .clk             (clk),
    .rst             (rst),
    .squash_o        (squash_o),
    .rob_squashing_o (rob_squashing_o),
    .mispred_o       (mispred_o),
    .conflict_o      (conflict_o),
    .hold_o          (hold_o),
    .mispred_cnt_o   (mispred_cnt_o),
    .sq_cnt          (sq_cnt),
    .flush_v         (flush_v)
);

// File: tb/commit_squash_ctrl_bench.sv
`timescale 1ns/1ps
module commit_squash_ctrl_bench;
    localparam int NT = 4, SEQ_W = 16, PC_W = 32, LAT_W = 4, MCNT_W = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic [LAT_W-1:0]         cfg_trap_lat = '0;
    logic [NT-1:0]            trap_req = '0, tc_req = '0, ex_squash = '0, ex_incl = '0;
    logic [NT-1:0]            ex_mispred = '0, ex_taken = '0, rob_done = '0, rob_empty = '0;
    logic [NT-1:0]            ins_valid = '0, com_valid = '0;
    logic [NT-1:0][SEQ_W-1:0] ex_seq = '0, rob_head_seq = '0, ins_seq = '0;
    logic [NT-1:0][PC_W-1:0]  ex_next_pc = '0, com_pc = '0;
    logic [NT-1:0]            squash_o, rob_squashing_o, mispred_o, taken_o, conflict_o;
    logic [NT-1:0][SEQ_W-1:0] done_seq_o;
    logic [NT-1:0][PC_W-1:0]  redirect_pc_o;
    logic                     hold_o;
    logic [MCNT_W-1:0]        mispred_cnt_o;

    commit_squash_ctrl #(.NT(NT), .SEQ_W(SEQ_W), .PC_W(PC_W), .LAT_W(LAT_W), .MCNT_W(MCNT_W))
    u_commit_squash_ctrl (
        .clk(clk), .rst(rst), .cfg_trap_lat(cfg_trap_lat), .trap_req(trap_req), .tc_req(tc_req),
        .ex_squash(ex_squash), .ex_seq(ex_seq), .ex_incl(ex_incl), .ex_mispred(ex_mispred),
        .ex_taken(ex_taken), .ex_next_pc(ex_next_pc), .rob_done(rob_done), .rob_empty(rob_empty),
        .rob_head_seq(rob_head_seq), .ins_valid(ins_valid), .ins_seq(ins_seq),
        .com_valid(com_valid), .com_pc(com_pc), .squash_o(squash_o),
        .rob_squashing_o(rob_squashing_o), .done_seq_o(done_seq_o), .redirect_pc_o(redirect_pc_o),
        .mispred_o(mispred_o), .taken_o(taken_o), .conflict_o(conflict_o), .hold_o(hold_o),
        .mispred_cnt_o(mispred_cnt_o)
    );

    typedef struct {
        int               th;
        logic [SEQ_W-1:0] seq;
        logic [PC_W-1:0]  pc;
        logic             mis;
        string            rq;
    } exp_t;

    exp_t exp_q[$];
    int   n_checks = 0;
    int   n_errors = 0;
    bit   finished = 0;

    task automatic check(input string rq, input string what, input logic [63:0] act, input logic [63:0] expv);
        n_checks++;
        if (act !== expv) begin
            n_errors++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, expv);
        end
    endtask

    task automatic expect_sq(input int th, input logic [SEQ_W-1:0] seq, input logic [PC_W-1:0] pc,
                             input logic mis, input string rq);
        exp_t e;
        e.th = th; e.seq = seq; e.pc = pc; e.mis = mis; e.rq = rq;
        exp_q.push_back(e);
    endtask

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic mid();
        @(negedge clk);
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst) begin
            for (int t = 0; t < NT; t++) begin
                if (squash_o[t]) begin
                    if (exp_q.size() == 0) begin
                        check("R7", "unexpected squash thread", 64'(t), 64'hFF);
                    end else begin
                        exp_t e;
                        e = exp_q.pop_front();
                        check(e.rq, "squash thread", 64'(t), 64'(e.th));
                        check(e.rq, "done_seq", 64'(done_seq_o[t]), 64'(e.seq));
                        check(e.rq, "redirect", 64'(redirect_pc_o[t]), 64'(e.pc));
                        check(e.rq, "mispred", 64'(mispred_o[t]), 64'(e.mis));
                    end
                end
            end
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            n_errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        mid();
        check("R1", "squash after reset", 64'(squash_o), 64'h0);
        check("R1", "rob_sq after reset", 64'(rob_squashing_o), 64'h0);
        check("R1", "hold after reset", 64'(hold_o), 64'h0);
        check("R1", "mis count after reset", 64'(mispred_cnt_o), 64'h0);
        cyc();

        // thread 0: execute squash accepted, then a younger one rejected
        ins_valid[0] = 1; ins_seq[0] = 16'd10; com_valid[0] = 1; com_pc[0] = 32'h100;
        cyc();
        ins_valid = '0; com_valid = '0;
        ex_squash[0] = 1; ex_seq[0] = 16'd8; ex_mispred[0] = 1; ex_taken[0] = 1; ex_next_pc[0] = 32'h200;
        expect_sq(0, 16'd8, 32'h200, 1'b1, "R5");
        mid();
        check("R7", "taken forwarded", 64'(taken_o[0]), 64'h1);
        check("R7", "rob_sq with pulse", 64'(rob_squashing_o[0]), 64'h1);
        cyc();
        ex_squash = '0; ex_mispred = '0; ex_taken = '0;
        mid();
        check("R7", "squash is a pulse", 64'(squash_o[0]), 64'h0);
        check("R7", "rob_sq held", 64'(rob_squashing_o[0]), 64'h1);
        cyc();
        ex_squash[0] = 1; ex_seq[0] = 16'd9;
        mid();
        check("R5", "younger squash rejected", 64'(squash_o[0]), 64'h0);
        cyc();
        ex_squash = '0; rob_done[0] = 1;
        mid();
        check("R8", "rob_sq drops on done", 64'(rob_squashing_o[0]), 64'h0);
        cyc();
        rob_done = '0;

        // include flag
        ex_squash[0] = 1; ex_seq[0] = 16'd8; ex_incl[0] = 1; ex_next_pc[0] = 32'h300;
        expect_sq(0, 16'd7, 32'h300, 1'b0, "R6");
        mid(); cyc();
        ex_incl = '0; ex_seq[0] = 16'd8;
        mid();
        check("R6", "youngest moved to boundary", 64'(squash_o[0]), 64'h0);
        cyc();
        ex_seq[0] = 16'd7; ex_next_pc[0] = 32'h340;
        expect_sq(0, 16'd7, 32'h340, 1'b0, "R5");
        mid(); cyc();
        ex_squash = '0; rob_done[0] = 1;
        cyc();
        rob_done = '0;

        // thread 1: deferred trap
        cfg_trap_lat = 4'd3;
        com_valid[1] = 1; com_pc[1] = 32'h400; rob_head_seq[1] = 16'd20;
        ins_valid[1] = 1; ins_seq[1] = 16'd25;
        cyc();
        com_valid = '0; ins_valid = '0;
        trap_req[1] = 1;
        cyc();
        trap_req = '0;
        expect_sq(1, 16'd19, 32'h400, 1'b0, "R4");
        for (int i = 0; i < 3; i++) begin
            ex_squash[1] = 1; ex_seq[1] = 16'd5;
            mid();
            check("R2", "no squash before latency", 64'(squash_o[1]), 64'h0);
            cyc();
        end
        ex_squash = '0;
        mid();
        check("R2", "trap squash at latency", 64'(squash_o[1]), 64'h1);
        cyc();
        rob_done[1] = 1;
        cyc();
        rob_done = '0;

        // thread 2: context squash with empty buffer
        com_valid[2] = 1; com_pc[2] = 32'h800;
        cyc();
        com_valid = '0; rob_empty[2] = 1; tc_req[2] = 1;
        cyc();
        tc_req = '0;
        expect_sq(2, 16'd0, 32'h800, 1'b0, "R4");
        mid();
        check("R4", "full squash clears mispred", 64'(mispred_o[2]), 64'h0);
        cyc();
        rob_empty = '0; rob_done[2] = 1;
        cyc();
        rob_done = '0;

        // thread 3: trap and context conflict
        cfg_trap_lat = 4'd2;
        com_valid[3] = 1; com_pc[3] = 32'hC00; rob_head_seq[3] = 16'd50;
        cyc();
        com_valid = '0; trap_req[3] = 1;
        cyc();
        trap_req = '0; tc_req[3] = 1;
        cyc();
        tc_req = '0;
        mid();
        check("R3", "context held during trap wait", 64'(squash_o[3]), 64'h0);
        cyc();
        expect_sq(3, 16'd49, 32'hC00, 1'b0, "R3");
        expect_sq(3, 16'd49, 32'hC00, 1'b0, "R3");
        mid();
        check("R3", "conflict flagged", 64'(conflict_o[3]), 64'h1);
        cyc();
        mid();
        check("R3", "context issued later", 64'(squash_o[3]), 64'h1);
        check("R3", "conflict gone", 64'(conflict_o[3]), 64'h0);
        cyc();
        rob_done[3] = 1;
        cyc();
        rob_done = '0;

        // all threads squash together
        for (int t = 0; t < NT; t++) begin
            ex_squash[t] = 1; ex_mispred[t] = 1; ex_seq[t] = (t == 0) ? 16'd5 : 16'd0;
            ex_next_pc[t] = 32'h500 + 32'(t);
            expect_sq(t, ex_seq[t], ex_next_pc[t], 1'b1, "R10");
        end
        mid();
        check("R9", "hold when all flush", 64'(hold_o), 64'h1);
        cyc();
        ex_squash = '0; ex_mispred = '0;
        ins_valid[0] = 1; ins_seq[0] = 16'd100; com_valid[0] = 1; com_pc[0] = 32'hDEAD;
        mid();
        check("R9", "hold persists", 64'(hold_o), 64'h1);
        cyc();
        ins_valid = '0; com_valid = '0; rob_done[0] = 1;
        mid();
        check("R8", "hold drops on done", 64'(hold_o), 64'h0);
        cyc();
        rob_done = '0;
        ex_squash[0] = 1; ex_seq[0] = 16'd6;
        mid();
        check("R9", "insert under hold ignored", 64'(squash_o[0]), 64'h0);
        cyc();
        ex_squash = '0; rob_head_seq[0] = 16'd30; tc_req[0] = 1;
        cyc();
        tc_req = '0;
        expect_sq(0, 16'd29, 32'h100, 1'b0, "R9");
        mid();
        cyc();
        mid();
        check("R10", "mispredict count", 64'(mispred_cnt_o), 64'd5);
        check("R7", "all expected squashes seen", 64'(exp_q.size()), 64'd0);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule